// File: doc/BRIEF.md
# Link Fault Injection Sequencer

This unit sits beside a serial link controller's datapath and lets software arm deliberate faults in that datapath. There are six fault groups, covering CRC faults, sequence-number faults, DLLP faults, symbol and framing faults, flow-credit faults and duplicate or nullified TLPs. Each group has its own control word that holds an injection count and a type code. Some groups also hold a signed offset, and one group additionally holds a virtual-channel number.

Once software sets a group's start bit, the group is armed. Each eligible datapath event reported for that group then consumes one unit of its count. For each such event the unit raises a one-cycle corrupt strobe one clock later. The strobe carries the group number, the type code, the offset and the channel. A group disarms itself when its count is used up. Only one strobe can leave per cycle. When several armed groups see an event in the same cycle, the lowest-numbered group is served, and the others keep their counts.

Top module: `einj_top`

## Requirements
- R1: After reset every control word reads 0, the start/status word reads 0 and the strobe is low.
- R2: Group g's control word is at address 0x34+4*g. Its fields are: count in bits 7:0; type code from bit 8 with a width of 4 bits for group 0, 1 bit for groups 1 and 5, 2 bits for group 2 and 3 bits for groups 3 and 4; offset in bits 28:16 for groups 1 and 4 only; channel in bits 14:12 for group 4 only. All other bits read back as 0.
- R3: Writing address 0x30 with bit n set arms group n and loads its remaining count from its control word. Bits written as 0 leave the other groups unchanged. Reading 0x30 returns a 1 in bit n for every armed group.
- R4: An event on an armed group with count left produces, on the next clock, a one-cycle strobe carrying that group's number and fields, and decrements the count. After the last count is used the group disarms, and further events produce no strobe.
- R5: Arming a group whose count is 0 produces no strobe, and its status bit reads 0 one cycle after the arming write.
- R6: A control write to an armed group updates the fields carried by later strobes, but it does not change the remaining count. The count is reloaded only by the next arming write.
- R7: When several armed groups have an event in the same cycle, only the lowest-numbered group strobes. The others keep their counts and are served by later events.
- R8: An offset written as -4096 (raw 0x1000) is stored and emitted as -4095 (0x1001). Strobes from groups without an offset carry offset 0, and strobes from any group except 4 carry channel 0.
- R9: Events for a group that is not armed produce no strobe. This includes an event in the same cycle as the arming write.
- R10: A control write that coincides with an event for the same armed group still emits the fields held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr (combinational) |
| evt | input | 6 | Eligible-event flag per group |
| inj_stb | output | 1 | One-cycle corrupt strobe |
| inj_grp | output | 3 | Group number of the strobe |
| inj_type | output | 4 | Type code of the strobe |
| inj_ofs | output | 13 | Signed offset of the strobe |
| inj_vc | output | 3 | Virtual channel of the strobe |

## Verification
Two collisions are provoked on purpose. In the first, a control write to an armed group lands in the same cycle as that group's event. The strobe must show the old type code, the next strobe must show the new one, and the count must be left alone. In the second, an arming write coincides with an event for that group, and no strobe may appear. Simultaneous events on two armed groups are also driven, and each is judged by which group strobes first and by the status word read afterwards.

// File: rtl/einj_pkg.sv
`timescale 1ns/1ps
package einj_pkg;
  localparam int NUM_GRP   = 6;
  localparam int GRP_W     = $clog2(NUM_GRP);
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 8;
  localparam int TYPE_MAXW = 4;
  localparam int VC_W      = 3;
  localparam int OFS_W     = 13;
  localparam int CNT_LSB   = 0;
  localparam int TYPE_LSB  = 8;
  localparam int VC_LSB    = 12;
  localparam int OFS_LSB   = 16;
  localparam logic [ADDR_W-1:0] START_ADDR = 8'h30;
  localparam logic [ADDR_W-1:0] CTRL_BASE  = 8'h34;
  localparam logic [OFS_W-1:0]  OFS_NEG_EDGE = 13'h1000;

  typedef struct packed {
    logic [OFS_W-1:0]     ofs;
    logic [VC_W-1:0]      vc;
    logic [TYPE_MAXW-1:0] typ;
    logic [CNT_W-1:0]     cnt;
  } grp_cfg_t;

  function automatic int type_width(input int g);
    case (g)
      0:       return 4;
      2:       return 2;
      3, 4:    return 3;
      default: return 1;
    endcase
  endfunction

  function automatic bit has_offset(input int g);
    return (g == 1) || (g == 4);
  endfunction

  function automatic bit has_vc(input int g);
    return g == 4;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_to_word(input grp_cfg_t c);
    return {3'b000, c.ofs, 1'b0, c.vc, c.typ, c.cnt};
  endfunction
endpackage

// File: rtl/einj_group_slot.sv
`timescale 1ns/1ps
module einj_group_slot
  import einj_pkg::*;
#(
  parameter int GRP = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              start,
  input  logic              take,
  output grp_cfg_t          cfg,
  output logic              active,
  output logic              req_ok
);
  localparam int TW = type_width(GRP);
  localparam logic [TYPE_MAXW-1:0] TMASK = TYPE_MAXW'((1 << TW) - 1);

  grp_cfg_t         cfg_nx;
  logic [CNT_W-1:0] remain, remain_nx;
  logic             active_nx;
  logic             cnt_en;
  logic [OFS_W-1:0] ofs_raw;
  logic             unused_bits;

  assign unused_bits = ^{wdata[31:29], wdata[15]};
  assign ofs_raw     = wdata[OFS_LSB +: OFS_W];

  // decode of a control write: mask type, clip offset, drop absent fields
  always_comb begin
    cfg_nx.cnt = wdata[CNT_LSB +: CNT_W];
    cfg_nx.typ = wdata[TYPE_LSB +: TYPE_MAXW] & TMASK;
    if (has_offset(GRP))
      cfg_nx.ofs = (ofs_raw == OFS_NEG_EDGE) ? OFS_NEG_EDGE + 13'd1 : ofs_raw;
    else
      cfg_nx.ofs = '0;
    cfg_nx.vc = has_vc(GRP) ? wdata[VC_LSB +: VC_W] : '0;
  end

  // arm / consume / self-clear
  always_comb begin
    active_nx = active;
    remain_nx = remain;
    if (start) begin
      active_nx = 1'b1;
      remain_nx = cfg.cnt;
    end else if (active) begin
      if (remain == '0) begin
        active_nx = 1'b0;
      end else if (take) begin
        remain_nx = remain - 1'b1;
        if (remain == CNT_W'(1)) active_nx = 1'b0;
      end
    end
  end

  assign cnt_en = start | active;
  assign req_ok = active && (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      active <= 1'b0;
      remain <= '0;
    end else begin
      if (cfg_we) cfg <= cfg_nx;
      if (cnt_en) begin
        active <= active_nx;
        remain <= remain_nx;
      end
    end
  end

  // R9: the arbiter only serves a group that is armed and has credit
  assert_take_needs_credit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (active && remain != '0));
  // R5: an armed group with no count left drops out on the next edge
  assert_zero_count_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && remain == '0 && !start) |=> !active);
  // R6: a field update never disturbs the running count
  assert_write_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !start && !take) |=> remain == $past(remain));
  // R8: the stored offset never holds the excluded value
  assert_offset_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.ofs != OFS_NEG_EDGE);
endmodule

// File: rtl/einj_arbiter.sv
`timescale 1ns/1ps
module einj_arbiter
  import einj_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_GRP-1:0]   req,
  input  grp_cfg_t             cfg_all [NUM_GRP],
  output logic [NUM_GRP-1:0]   grant,
  output logic                 stb,
  output logic [GRP_W-1:0]     grp,
  output logic [TYPE_MAXW-1:0] typ,
  output logic [OFS_W-1:0]     ofs,
  output logic [VC_W-1:0]      vc
);
  logic [GRP_W-1:0]     grp_nx;
  logic [TYPE_MAXW-1:0] typ_nx;
  logic [OFS_W-1:0]     ofs_nx;
  logic [VC_W-1:0]      vc_nx;
  logic                 any_req;

  // fixed priority: lowest group number wins
  always_comb begin
    grant  = '0;
    grp_nx = '0;
    typ_nx = '0;
    ofs_nx = '0;
    vc_nx  = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (req[g]) begin
        grant    = '0;
        grant[g] = 1'b1;
        grp_nx   = GRP_W'(g);
        typ_nx   = cfg_all[g].typ;
        ofs_nx   = cfg_all[g].ofs;
        vc_nx    = cfg_all[g].vc;
      end
    end
  end

  assign any_req = |req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb <= 1'b0;
      grp <= '0;
      typ <= '0;
      ofs <= '0;
      vc  <= '0;
    end else begin
      stb <= any_req;
      if (any_req) begin
        grp <= grp_nx;
        typ <= typ_nx;
        ofs <= ofs_nx;
        vc  <= vc_nx;
      end
    end
  end

  // R7: at most one group is served per cycle
  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R4: any eligible request yields a strobe on the next cycle
  assert_strobe_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> stb);
endmodule

// File: rtl/einj_top.sv
`timescale 1ns/1ps
module einj_top
  import einj_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [5:0]  evt,
  output logic        inj_stb,
  output logic [2:0]  inj_grp,
  output logic [3:0]  inj_type,
  output logic [12:0] inj_ofs,
  output logic [2:0]  inj_vc
);
  grp_cfg_t           cfg_all [NUM_GRP];
  logic [NUM_GRP-1:0] active, req_ok, req, grant, start, cfg_we;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] MY_ADDR = CTRL_BASE + ADDR_W'(4 * g);
    assign start[g]  = wr_en && (addr == START_ADDR) && wdata[g];
    assign cfg_we[g] = wr_en && (addr == MY_ADDR);
    assign req[g]    = evt[g] && req_ok[g];

    einj_group_slot #(.GRP(g)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_we (cfg_we[g]),
      .wdata  (wdata),
      .start  (start[g]),
      .take   (grant[g]),
      .cfg    (cfg_all[g]),
      .active (active[g]),
      .req_ok (req_ok[g])
    );
  end

  einj_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .cfg_all (cfg_all),
    .grant   (grant),
    .stb     (inj_stb),
    .grp     (inj_grp),
    .typ     (inj_type),
    .ofs     (inj_ofs),
    .vc      (inj_vc)
  );

  always_comb begin
    rdata = '0;
    if (addr == START_ADDR) rdata = DATA_W'(active);
    for (int g = 0; g < NUM_GRP; g++)
      if (addr == CTRL_BASE + ADDR_W'(4 * g)) rdata = cfg_to_word(cfg_all[g]);
  end

  // R8: offset and channel are zero for groups that do not carry them
  assert_plain_group_no_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_stb && inj_grp != 3'd1 && inj_grp != 3'd4) |-> (inj_ofs == '0));
  assert_channel_only_group4_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_stb && inj_grp != 3'd4) |-> (inj_vc == '0));
  // R4: a strobe only names a group that exists
  assert_group_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inj_stb |-> (inj_grp < 3'(NUM_GRP)));
endmodule

// File: tb/sim_einj_top.sv
`timescale 1ns/1ps
module sim_einj_top;
  logic        clk = 1'b0;
  logic        rst_n, wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [5:0]  evt;
  logic        inj_stb;
  logic [2:0]  inj_grp, inj_vc;
  logic [3:0]  inj_type;
  logic [12:0] inj_ofs;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  einj_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt(evt), .inj_stb(inj_stb), .inj_grp(inj_grp),
    .inj_type(inj_type), .inj_ofs(inj_ofs), .inj_vc(inj_vc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(input logic [5:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic expect_inj(input string tag, input int g, input int t,
                            input logic [12:0] o, input logic [2:0] v);
    chk({tag, " strobe"}, 32'(inj_stb), 32'd1);
    chk({tag, " group"},  32'(inj_grp), 32'(g));
    chk({tag, " type"},   32'(inj_type), 32'(t));
    chk({tag, " offset"}, 32'(inj_ofs), 32'(o));
    chk({tag, " vc"},     32'(inj_vc), 32'(v));
  endtask

  function automatic logic [7:0] ca(input int g);
    return 8'h34 + 8'(4 * g);
  endfunction

  task automatic t_reset;
    chk("R1 strobe after reset", 32'(inj_stb), 32'd0);
    rd_chk("R1 status after reset", 8'h30, 32'd0);
    for (int g = 0; g < 6; g++) rd_chk("R1 ctrl after reset", ca(g), 32'd0);
  endtask

  task automatic t_regmap;
    logic [31:0] exp [6];
    exp[0] = 32'h0000_0FFF; exp[1] = 32'h1FFF_01FF; exp[2] = 32'h0000_03FF;
    exp[3] = 32'h0000_07FF; exp[4] = 32'h1FFF_77FF; exp[5] = 32'h0000_01FF;
    for (int g = 0; g < 6; g++) begin
      wr(ca(g), 32'hFFFF_FFFF);
      rd_chk("R2 field readback", ca(g), exp[g]);
      wr(ca(g), 32'd0);
    end
  endtask

  task automatic t_basic;
    wr(ca(2), 32'h0000_0203);
    wr(8'h30, 32'h4);
    rd_chk("R3 status shows armed group", 8'h30, 32'h4);
    for (int i = 0; i < 3; i++) begin
      pulse(6'h04);
      expect_inj("R4 group2 inject", 2, 2, 13'd0, 3'd0);
    end
    rd_chk("R4 disarm after count", 8'h30, 32'h0);
    pulse(6'h04);
    chk("R4 no strobe after count used", 32'(inj_stb), 32'd0);
  endtask

  task automatic t_zero;
    wr(ca(3), 32'h0000_0300);
    wr(8'h30, 32'h8);
    pulse(6'h08);
    chk("R5 zero count no strobe", 32'(inj_stb), 32'd0);
    rd_chk("R5 zero count disarms", 8'h30, 32'h0);
  endtask

  task automatic t_offset;
    wr(ca(4), 32'h1000_6502);
    rd_chk("R8 offset clipped", ca(4), 32'h1001_6502);
    wr(8'h30, 32'h10);
    pulse(6'h10);
    expect_inj("R8 group4 inject", 4, 5, 13'h1001, 3'd6);
    pulse(6'h10);
    wr(ca(1), 32'h0FFF_0101);
    rd_chk("R2 group1 readback", ca(1), 32'h0FFF_0101);
    wr(8'h30, 32'h2);
    pulse(6'h02);
    expect_inj("R8 group1 inject", 1, 1, 13'h0FFF, 3'd0);
  endtask

  task automatic t_update;
    wr(ca(0), 32'h0000_0103);
    wr(8'h30, 32'h1);
    pulse(6'h01);
    expect_inj("R6 before update", 0, 1, 13'd0, 3'd0);
    wr(ca(0), 32'h0000_0B09);
    pulse(6'h01);
    expect_inj("R6 after update", 0, 11, 13'd0, 3'd0);
    pulse(6'h01);
    expect_inj("R6 last of old count", 0, 11, 13'd0, 3'd0);
    rd_chk("R6 count not reloaded by write", 8'h30, 32'h0);
  endtask

  task automatic t_prio;
    wr(ca(0), 32'h0000_0401);
    wr(ca(5), 32'h0000_0101);
    wr(8'h30, 32'h21);
    pulse(6'h21);
    expect_inj("R7 lowest group wins", 0, 4, 13'd0, 3'd0);
    rd_chk("R7 loser stays armed", 8'h30, 32'h20);
    pulse(6'h20);
    expect_inj("R7 loser served later", 5, 1, 13'd0, 3'd0);
    rd_chk("R7 all done", 8'h30, 32'h0);
  endtask

  task automatic t_ignore;
    wr(ca(2), 32'h0000_0002);
    pulse(6'h04);
    chk("R9 unarmed event ignored", 32'(inj_stb), 32'd0);
    wr_en = 1'b1; addr = 8'h30; wdata = 32'h4; evt = 6'h04;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; evt = '0;
    chk("R9 event with arming write ignored", 32'(inj_stb), 32'd0);
    wr(8'h30, 32'h0);
    rd_chk("R3 zero bits leave group armed", 8'h30, 32'h4);
    pulse(6'h04);
    expect_inj("R9 count intact", 2, 0, 13'd0, 3'd0);
    pulse(6'h04);
    expect_inj("R9 second inject", 2, 0, 13'd0, 3'd0);
    rd_chk("R9 disarmed", 8'h30, 32'h0);
  endtask

  task automatic t_collide;
    wr(ca(3), 32'h0000_0302);
    wr(8'h30, 32'h8);
    wr_en = 1'b1; addr = ca(3); wdata = 32'h0000_0702; evt = 6'h08;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; evt = '0;
    expect_inj("R10 old fields on collision", 3, 3, 13'd0, 3'd0);
    pulse(6'h08);
    expect_inj("R10 new fields next", 3, 7, 13'd0, 3'd0);
    rd_chk("R10 count unaffected", 8'h30, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_basic();
    t_zero();
    t_offset();
    t_update();
    t_prio();
    t_ignore();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule